// File: doc/BRIEF.md
# Reed-Solomon Block Encoder (255,239)

This block turns a stream of 8-bit data symbols into systematic Reed-Solomon codewords. Each codeword holds 239 data symbols followed by 16 check symbols, 255 symbols in all. The code can detect up to 16 corrupted symbols in a codeword and correct up to 8. Data bytes arrive one per cycle with a write strobe. Each accepted byte leaves the block unchanged, one cycle later, with a valid strobe. After the 239th data byte the block emits the 16 check symbols on its own, one per cycle, and then returns to accepting data. The output is meant to feed a FIFO directly, so it has no back-pressure.

The check symbols come from a 16-stage linear-feedback shift register over GF(2^8). Each stage holds one byte and is fed through fixed constant multipliers. A small state machine has two states. In `ST_DATA` the encoder accepts data. In `ST_PARITY` it shifts out the check symbols. The machine has five named transitions:

- DATA_HOLD: no write is pending, so nothing advances.
- DATA_ACCEPT: a data byte is taken.
- DATA_TO_PARITY: the 239th data byte has been taken.
- PARITY_SHIFT: one check symbol is emitted.
- PARITY_TO_DATA: the 16th check symbol has been emitted.

Flags mark the first and the last symbol of every codeword.

Top module: `rs_block_encoder`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) drives out_valid, out_sop and out_eop low. It also clears the symbol counter and every parity stage, so the next accepted byte starts a fresh codeword, even if the reset came in the middle of one.
- R2: In the data phase, a byte written with in_wr high appears on out_data with out_valid high exactly one cycle later, unchanged.
- R3: Right after the 239th data byte, 16 check symbols follow on consecutive cycles. They are the coefficients of m(x)*x^16 mod g(x), sent from x^15 down to x^0, where the first data byte is the highest-degree coefficient of m(x). Here g(x) is the product of (x + a^i) for i = 0..15, the field polynomial is x^8+x^4+x^3+x^2+1 (0x11D) and a = 0x02. Every codeword therefore evaluates to zero at a^0..a^15.
- R4: During the 16 check-symbol cycles, in_wr and in_data are ignored. Neither the check symbols nor the next codeword depend on them.
- R5: In the data phase, a cycle with in_wr low produces no output (out_valid low one cycle later) and does not advance the codeword position (bypass).
- R6: out_sop is high together with output symbol 0 of each codeword, and out_eop is high together with output symbol 254. Both are low on every other symbol.
- R7: The parity register is all zero once the last check symbol has left. Codewords sent back to back, with no idle cycle between them, are encoded independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_wr | input | 1 | Write strobe for in_data |
| in_data | input | 8 | Data symbol |
| out_valid | output | 1 | out_data holds an encoded symbol |
| out_data | output | 8 | Encoded symbol (data or check) |
| out_sop | output | 1 | First symbol of a codeword |
| out_eop | output | 1 | Last symbol of a codeword |

## Verification
Every output is registered once, with the following timing:

- A data byte written at a rising edge is due on the outputs right after that same edge.
- The first check symbol is due one edge after the 239th data byte, and the remaining check symbols follow one per edge.
- An idle data-phase cycle shows out_valid low after its edge.

The bench drives inputs just after a rising edge and pushes each expected symbol, with its flags, into a queue before the edge that produces it. A monitor pops and compares on the falling edge. The bypass checks read out_valid just after the idle edge. The check symbols are predicted by long division in the bench, and a running evaluation at a^0..a^15 confirms each full codeword independently.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
    localparam int SYM_W = 8;
    localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;
    localparam int MAX_PAR = 32;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic {
        ST_DATA   = 1'b0,
        ST_PARITY = 1'b1
    } enc_state_e;

    // multiply by alpha (x) modulo the field polynomial
    function automatic sym_t gf_xtime(sym_t a);
        sym_t r;
        r = {a[SYM_W-2:0], 1'b0};
        if (a[SYM_W-1]) r = r ^ FIELD_POLY[SYM_W-1:0];
        return r;
    endfunction

    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // coefficient idx of prod_{i<npar} (x + alpha^(first_root+i))
    function automatic sym_t gen_coef(int idx, int npar, int first_root);
        sym_t g [0:MAX_PAR];
        sym_t root;
        for (int i = 0; i <= MAX_PAR; i++) g[i] = '0;
        g[0] = sym_t'(1);
        root = sym_t'(1);
        for (int i = 0; i < first_root; i++) root = gf_xtime(root);
        for (int i = 0; i < npar; i++) begin
            for (int j = MAX_PAR; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
            g[0] = gf_mul(g[0], root);
            root = gf_xtime(root);
        end
        return g[idx];
    endfunction
endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul
    import rs_enc_pkg::*;
#(
    parameter logic [rs_enc_pkg::SYM_W-1:0] COEF = '0
) (
    input  logic [rs_enc_pkg::SYM_W-1:0] a,
    output logic [rs_enc_pkg::SYM_W-1:0] y
);
    always_comb y = gf_mul(a, COEF);
endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
    import rs_enc_pkg::*;
#(
    parameter int NPAR       = 16,
    parameter int FIRST_ROOT = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  feed,
    input  logic                  shift,
    input  logic [SYM_W-1:0]      din,
    output logic [SYM_W-1:0]      top_sym,
    output logic [NPAR*SYM_W-1:0] regs_flat
);
    sym_t par_q [NPAR];
    sym_t prod  [NPAR];
    sym_t fb;

    assign fb      = din ^ par_q[NPAR-1];
    assign top_sym = par_q[NPAR-1];

    for (genvar i = 0; i < NPAR; i++) begin : g_stage
        rs_gf_cmul #(.COEF(gen_coef(i, NPAR, FIRST_ROOT))) u_mul (
            .a (fb),
            .y (prod[i])
        );
        assign regs_flat[i*SYM_W +: SYM_W] = par_q[i];
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)        par_q[i] <= '0;
                else if (feed)  par_q[i] <= prod[i];
                else if (shift) par_q[i] <= '0;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)        par_q[i] <= '0;
                else if (feed)  par_q[i] <= par_q[i-1] ^ prod[i];
                else if (shift) par_q[i] <= par_q[i-1];
            end
        end
    end

    // feeding and shifting come from the controller and never overlap
    assert_feed_shift_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(feed && shift));
endmodule

// File: rtl/rs_symbol_ctrl.sv
module rs_symbol_ctrl
    import rs_enc_pkg::*;
#(
    parameter int N_SYM = 255,
    parameter int K_SYM = 239
) (
    input  logic clk,
    input  logic rst,
    input  logic in_wr,
    output logic feed,
    output logic shift,
    output logic valid_q,
    output logic sop_q,
    output logic eop_q
);
    localparam int CNT_W = $clog2(N_SYM);

    enc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             at_first, last_par;

    assign at_first = (cnt_q == '0);
    assign last_par = (cnt_q == CNT_W'(N_SYM-1));

    // next state: DATA_HOLD, DATA_ACCEPT, DATA_TO_PARITY, PARITY_SHIFT, PARITY_TO_DATA
    always_comb begin
        feed    = 1'b0;
        shift   = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_DATA: begin
                feed = in_wr;
                if (in_wr && cnt_q == CNT_W'(K_SYM-1)) state_d = ST_PARITY;
            end
            ST_PARITY: begin
                shift = 1'b1;
                if (last_par) state_d = ST_DATA;
            end
            default: state_d = ST_DATA;
        endcase
    end

    // state register and symbol position
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (feed || shift) cnt_q <= (shift && last_par) ? '0 : cnt_q + 1'b1;
        end
    end

    // registered output flags
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            sop_q   <= 1'b0;
            eop_q   <= 1'b0;
        end else begin
            valid_q <= feed || shift;
            sop_q   <= feed && at_first;
            eop_q   <= shift && last_par;
        end
    end

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(N_SYM));
    assert_bypass_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && !in_wr) |=> (!valid_q && $stable(cnt_q)));
    assert_parity_run_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PARITY) |=> valid_q);
    assert_flags_valid_R6: assert property (@(posedge clk) disable iff (rst)
        (sop_q || eop_q) |-> (valid_q && !(sop_q && eop_q)));
endmodule

// File: rtl/rs_block_encoder.sv
module rs_block_encoder
    import rs_enc_pkg::*;
#(
    parameter int N_SYM      = 255,
    parameter int K_SYM      = 239,
    parameter int FIRST_ROOT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_wr,
    input  logic [SYM_W-1:0] in_data,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_data,
    output logic             out_sop,
    output logic             out_eop
);
    localparam int NPAR = N_SYM - K_SYM;

    logic                  feed, shift;
    logic [SYM_W-1:0]      par_top;
    logic [NPAR*SYM_W-1:0] par_regs;

    rs_symbol_ctrl #(.N_SYM(N_SYM), .K_SYM(K_SYM)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .in_wr   (in_wr),
        .feed    (feed),
        .shift   (shift),
        .valid_q (out_valid),
        .sop_q   (out_sop),
        .eop_q   (out_eop)
    );

    rs_parity_lfsr #(.NPAR(NPAR), .FIRST_ROOT(FIRST_ROOT)) u_lfsr (
        .clk       (clk),
        .rst       (rst),
        .feed      (feed),
        .shift     (shift),
        .din       (in_data),
        .top_sym   (par_top),
        .regs_flat (par_regs)
    );

    always_ff @(posedge clk) begin
        if (rst)        out_data <= '0;
        else if (shift) out_data <= par_top;
        else if (feed)  out_data <= in_data;
    end

    assert_data_pass_R2: assert property (@(posedge clk) disable iff (rst)
        feed |=> (out_valid && out_data == $past(in_data)));
    assert_lfsr_empty_R7: assert property (@(posedge clk) disable iff (rst)
        out_eop |-> (par_regs == '0));
endmodule

// File: tb/rs_block_encoder_bench.sv
module rs_block_encoder_bench;
    localparam int N = 255;
    localparam int K = 239;
    localparam int P = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_wr = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid, out_sop, out_eop;
    logic [7:0] out_data;

    always #2 clk = ~clk;

    rs_block_encoder u_rs_block_encoder (
        .clk(clk), .rst(rst), .in_wr(in_wr), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [9:0] expq [$];
    string      tagq [$];
    logic [7:0] gen  [0:P];
    logic [7:0] apow [0:P-1];
    logic [7:0] msg  [0:K-1];
    logic [7:0] work [0:N-1];
    logic [7:0] synd [0:P-1];

    function automatic logic [7:0] bmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            r = r[7] ? ({r[6:0], 1'b0} ^ 8'h1D) : {r[6:0], 1'b0};
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    task automatic check(string req, bit ok, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop expected symbols and track syndromes
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (expq.size() == 0) begin
                check("R5", 1'b0, {22'd0, out_sop, out_eop, out_data}, 32'hFFFF);
            end else begin
                logic [9:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                check(t, out_data == e[7:0], out_data, e[7:0]);
                check("R6", {out_sop, out_eop} == e[9:8], {out_sop, out_eop}, e[9:8]);
            end
            for (int i = 0; i < P; i++) begin
                logic [7:0] s;
                s = out_sop ? 8'h00 : synd[i];
                synd[i] = bmul(s, apow[i]) ^ out_data;
            end
            if (out_eop) begin
                for (int i = 0; i < P; i++)
                    check("R3", synd[i] == 8'h00, synd[i], 0);
            end
        end
    end

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            in_wr = 1'b0;
            @(posedge clk); #1;
            check("R5", out_valid == 1'b0, out_valid, 0);
        end
    endtask

    task automatic fill_msg(int pattern);
        for (int i = 0; i < K; i++) begin
            case (pattern)
                0: msg[i] = 8'h00;
                1: msg[i] = 8'(i);
                2: msg[i] = 8'($urandom);
                3: msg[i] = 8'hFF;
                default: msg[i] = (i == 0) ? 8'h01 : 8'h00;
            endcase
        end
    endtask

    // long division of m(x)*x^16 by the bench generator
    task automatic compute_parity();
        for (int i = 0; i < N; i++) work[i] = (i < K) ? msg[i] : 8'h00;
        for (int i = 0; i < K; i++) begin
            logic [7:0] c;
            c = work[i];
            for (int j = 1; j <= P; j++) work[i+j] = work[i+j] ^ bmul(c, gen[P-j]);
        end
    endtask

    task automatic send_cw(int pattern, bit gaps);
        fill_msg(pattern);
        compute_parity();
        for (int i = 0; i < K; i++) begin
            if (gaps && ($urandom % 5 == 0)) idle(1 + ($urandom % 2));
            in_wr = 1'b1;
            in_data = msg[i];
            expq.push_back({(i == 0), 1'b0, msg[i]});
            tagq.push_back("R2");
            @(posedge clk); #1;
        end
        for (int j = 0; j < P; j++) begin
            expq.push_back({1'b0, (j == P-1), work[K+j]});
            tagq.push_back("R3 R4");
        end
        // junk writes during the parity phase must be ignored (R4)
        for (int j = 0; j < P; j++) begin
            in_wr = 1'b1;
            in_data = 8'($urandom);
            @(posedge clk); #1;
        end
        in_wr = 1'b0;
    endtask

    initial begin
        logic [7:0] tmp [0:P];
        apow[0] = 8'h01;
        for (int i = 1; i < P; i++) apow[i] = bmul(apow[i-1], 8'h02);
        for (int i = 0; i <= P; i++) gen[i] = 8'h00;
        gen[0] = 8'h01;
        for (int r = 0; r < P; r++) begin
            for (int k = 0; k <= P; k++)
                tmp[k] = ((k > 0) ? gen[k-1] : 8'h00) ^ bmul(gen[k], apow[r]);
            for (int k = 0; k <= P; k++) gen[k] = tmp[k];
        end
        for (int i = 0; i < P; i++) synd[i] = 8'h00;

        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", {out_valid, out_sop, out_eop} == 3'b000, {out_valid, out_sop, out_eop}, 0);
        rst = 1'b0;
        idle(2);

        send_cw(0, 1'b0);        // all-zero data gives all-zero parity
        idle(3);
        send_cw(1, 1'b0);        // R7: followed back to back
        send_cw(2, 1'b1);        // random data with bypass gaps
        idle(2);

        // R1: reset in the middle of a codeword
        for (int i = 0; i < 100; i++) begin
            in_wr = 1'b1;
            in_data = 8'($urandom);
            expq.push_back({(i == 0), 1'b0, in_data});
            tagq.push_back("R2");
            @(posedge clk); #1;
        end
        idle(1);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1", {out_valid, out_sop, out_eop} == 3'b000, {out_valid, out_sop, out_eop}, 0);
        check("R1", expq.size() == 0, expq.size(), 0);
        expq.delete();
        tagq.delete();
        rst = 1'b0;

        send_cw(3, 1'b0);
        send_cw(4, 1'b1);
        idle(2);
        check("R3", expq.size() == 0, expq.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule